// File: doc/BRIEF.md
# Load-Use Stall Controller

This block sits beside the register-operand stages of a five-stage in-order pipeline. It finds the register dependences that result forwarding cannot cover in time, and it freezes the fetch and decode stages for as long as one of them is pending. The stages from execute onward keep advancing. While the front is frozen, the execute-stage pipeline register is loaded with a nop, so work already ahead of the stall drains normally.

Each cycle the controller looks at three things: the opcode and register fields of the decode-stage instruction, the opcode, destination and valid bit of the execute-stage instruction, and its own one-entry record of a load that left execute on the previous edge. Two kinds of value arrive too late for a consumer. A loaded value reaches no consumer in the next slot. A branch resolves its target and condition in decode, so it needs its registers even earlier. The stall condition is evaluated again every cycle. A conflict that needs two slots of separation therefore produces two consecutive stall cycles without any counter.

The block computes nothing itself. The pause output drives the register enables of stages 1 and 2, and the bubble output forces a nop into stage 3.

Top module: `ldu_stall_ctrl`

## Requirements
- R1: Opcode values are: 0 nop, 1 add, 2 sub, 3 add-immediate, 4 load-address, 5 load, 6 store, 7 branch, 8 branch-and-link. When stage 3 holds a valid load (opcode 5) whose destination equals a register that the stage-2 instruction uses as an operand, pause is high. Operand fields by opcode: add/sub read fb and fc; add-immediate, load-address and load read fb; store reads fb (base) and fa (data).
- R2: Branch and branch-and-link (7, 8) read fb (target) and fc (condition) in stage 2. A valid load in stage 3 whose destination matches either of these raises pause.
- R3: With LOAD_BR_GAP=2, a valid load that was in stage 3 on the previous cycle raises pause when its destination matches the fb or fc field of a stage-2 branch. It does not raise pause when it matches only an operand of a non-branch.
- R4: A valid add, sub, add-immediate or load-address in stage 3 raises pause only when its destination matches a stage-2 branch's fb or fc. A match with an operand of a non-branch gives no pause.
- R5: A stage-3 instruction with its valid bit low, or one that writes no hazard-bearing result (nop, store, branch, branch-and-link), raises no pause.
- R6: Fields that the stage-2 opcode does not read have no effect. For example, fc of add-immediate and fc of store matching a stage-3 load gives no pause.
- R7: bubble_s3 equals pause_front in every cycle. Both follow the inputs combinationally in the same cycle.
- R8: Reset, which is asynchronous and active low, clears the record of the previous stage-3 load, so no stall arises from a load seen before reset.
- R9: Opcodes outside 0 to 8 read and write nothing and cause no pause in either stage.
- R10: With LOAD_BR_GAP=1 the previous-cycle load record is absent, and a branch needs only one slot of separation from a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s2_op | input | OP_W | Opcode of the decode-stage instruction |
| s2_fa | input | $clog2(NREG) | Register field a of the decode-stage instruction (store data) |
| s2_fb | input | $clog2(NREG) | Register field b (base, first operand, branch target) |
| s2_fc | input | $clog2(NREG) | Register field c (second operand, branch condition) |
| s3_op | input | OP_W | Opcode of the execute-stage instruction |
| s3_dst | input | $clog2(NREG) | Destination register of the execute-stage instruction |
| s3_vld | input | 1 | Execute-stage slot holds a real instruction |
| pause_front | output | 1 | Hold the stage 1 and 2 registers this cycle |
| bubble_s3 | output | 1 | Load a nop into the stage 3 register this cycle |

## Verification
The bench builds two copies side by side. One uses the defaults (32 registers, LOAD_BR_GAP=2). The other uses 16 registers and LOAD_BR_GAP=1, so the generate branch without a load record is exercised alongside the full one. Running both on the same stream shows the two-cycle branch-after-load stall in the first copy and the single-cycle one in the second. It also checks that the narrower register field compares correctly. Short instruction sequences drive each opcode class against matching, non-matching and unread fields, plus a reset placed between a load and a dependent branch.

// File: rtl/ldu_pkg.sv
package ldu_pkg;

   localparam logic [31:0] OPC_NOP   = 32'd0;
   localparam logic [31:0] OPC_ADD   = 32'd1;
   localparam logic [31:0] OPC_SUB   = 32'd2;
   localparam logic [31:0] OPC_ADDI  = 32'd3;
   localparam logic [31:0] OPC_LDADR = 32'd4;
   localparam logic [31:0] OPC_LOAD  = 32'd5;
   localparam logic [31:0] OPC_STORE = 32'd6;
   localparam logic [31:0] OPC_BR    = 32'd7;
   localparam logic [31:0] OPC_BRL   = 32'd8;

   // Register usage and result timing of one opcode
   typedef struct packed {
      logic rd_a;      // field a read as operand (store data)
      logic rd_b;      // field b read as operand
      logic rd_c;      // field c read as operand
      logic br_rd;     // fields b and c read in decode (branch)
      logic wr_early;  // result forwardable from execute output
      logic wr_late;   // result only after memory access
   } ldu_cls_t;

   function automatic ldu_cls_t ldu_classify(input logic [31:0] code);
      ldu_cls_t c;
      c = '0;
      case (code)
         OPC_ADD, OPC_SUB: begin
            c.rd_b = 1'b1;
            c.rd_c = 1'b1;
            c.wr_early = 1'b1;
         end
         OPC_ADDI, OPC_LDADR: begin
            c.rd_b = 1'b1;
            c.wr_early = 1'b1;
         end
         OPC_LOAD: begin
            c.rd_b = 1'b1;
            c.wr_late = 1'b1;
         end
         OPC_STORE: begin
            c.rd_b = 1'b1;
            c.rd_a = 1'b1;
         end
         OPC_BR, OPC_BRL: begin
            c.br_rd = 1'b1;
         end
         default: c = '0;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/ldu_dec.sv
module ldu_dec #(
   parameter int OP_W = 5
) (
   input  logic [OP_W-1:0]  op,
   output ldu_pkg::ldu_cls_t cls_o
);

   always_comb begin
      cls_o = ldu_pkg::ldu_classify(32'(op));
   end

endmodule

// File: rtl/ldu_hit.sv
module ldu_hit #(
   parameter int RW = 5
) (
   input  logic [RW-1:0]     fa,
   input  logic [RW-1:0]     fb,
   input  logic [RW-1:0]     fc,
   input  ldu_pkg::ldu_cls_t cls,
   input  logic [RW-1:0]     pdst,
   input  logic              pvld,
   output logic              op_hit,
   output logic              br_hit
);

   logic eq_a, eq_b, eq_c;

   always_comb begin
      eq_a   = (fa == pdst);
      eq_b   = (fb == pdst);
      eq_c   = (fc == pdst);
      op_hit = pvld && ((cls.rd_a && eq_a) || (cls.rd_b && eq_b) || (cls.rd_c && eq_c));
      br_hit = pvld && cls.br_rd && (eq_b || eq_c);
   end

endmodule

// File: rtl/ldu_trail.sv
module ldu_trail #(
   parameter int RW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_vld,
   input  logic [RW-1:0] in_dst,
   output logic          out_vld,
   output logic [RW-1:0] out_dst
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_vld <= 1'b0;
         out_dst <= '0;
      end else begin
         out_vld <= in_vld;
         out_dst <= in_dst;
      end
   end

   // R3: a load leaving execute is remembered for exactly one cycle
   p_trail_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |=> (out_vld && out_dst == $past(in_dst)));

   // R8: nothing remembered right after reset release
   p_trail_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !out_vld);

endmodule

// File: rtl/ldu_stall_ctrl.sv
module ldu_stall_ctrl #(
   parameter int NREG        = 32,
   parameter int OP_W        = 5,
   parameter int LOAD_BR_GAP = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [OP_W-1:0]          s2_op,
   input  logic [$clog2(NREG)-1:0]  s2_fa,
   input  logic [$clog2(NREG)-1:0]  s2_fb,
   input  logic [$clog2(NREG)-1:0]  s2_fc,
   input  logic [OP_W-1:0]          s3_op,
   input  logic [$clog2(NREG)-1:0]  s3_dst,
   input  logic                     s3_vld,
   output logic                     pause_front,
   output logic                     bubble_s3
);

   localparam int RW = $clog2(NREG);

   generate
      if (NREG < 2 || NREG > 1024) begin : g_bad_nreg
         $error("ldu_stall_ctrl: NREG out of range");
      end
      if (OP_W < 4) begin : g_bad_opw
         $error("ldu_stall_ctrl: OP_W too narrow for opcode set");
      end
      if (LOAD_BR_GAP != 1 && LOAD_BR_GAP != 2) begin : g_bad_gap
         $error("ldu_stall_ctrl: LOAD_BR_GAP must be 1 or 2");
      end
   endgenerate

   ldu_pkg::ldu_cls_t cls2, cls3;
   logic prod3_vld, op_hit3, br_hit3;
   logic late_conf, early_conf, stall;
   logic trail_vld, trail_op_hit, trail_br_hit;

   ldu_dec #(.OP_W(OP_W)) u_dec2 (.op(s2_op), .cls_o(cls2));
   ldu_dec #(.OP_W(OP_W)) u_dec3 (.op(s3_op), .cls_o(cls3));

   assign prod3_vld = s3_vld && (cls3.wr_early || cls3.wr_late);

   ldu_hit #(.RW(RW)) u_hit3 (
      .fa(s2_fa), .fb(s2_fb), .fc(s2_fc), .cls(cls2),
      .pdst(s3_dst), .pvld(prod3_vld),
      .op_hit(op_hit3), .br_hit(br_hit3)
   );

   generate
      if (LOAD_BR_GAP == 2) begin : g_trail
         logic [RW-1:0] trail_dst;
         ldu_trail #(.RW(RW)) u_trail (
            .clk(clk), .rst_n(rst_n),
            .in_vld(s3_vld && cls3.wr_late), .in_dst(s3_dst),
            .out_vld(trail_vld), .out_dst(trail_dst)
         );
         ldu_hit #(.RW(RW)) u_hit4 (
            .fa(s2_fa), .fb(s2_fb), .fc(s2_fc), .cls(cls2),
            .pdst(trail_dst), .pvld(trail_vld),
            .op_hit(trail_op_hit), .br_hit(trail_br_hit)
         );
      end else begin : g_no_trail
         assign trail_vld    = 1'b0;
         assign trail_op_hit = 1'b0;
         assign trail_br_hit = 1'b0;
      end
   endgenerate

   assign late_conf  = cls3.wr_late && (op_hit3 || br_hit3);
   assign early_conf = cls3.wr_early && br_hit3;
   assign stall      = late_conf || early_conf || trail_br_hit;

   assign pause_front = stall;
   assign bubble_s3   = stall;

   // R1: loaded value needed as first operand next slot
   p_load_operand_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (s3_vld && s3_op == OP_W'(5) && cls2.rd_b && s2_fb == s3_dst) |-> pause_front);

   // R3: a trailing load never holds back a plain operand reader
   p_trail_operand_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (trail_op_hit && !s3_vld) |-> !pause_front);

   // R4: ALU result forwarded to a non-branch without stalling
   p_alu_forward_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (s3_vld && cls3.wr_early && !cls2.br_rd && !trail_vld) |-> !pause_front);

   // R5: empty execute slot and no load record means no stall
   p_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!s3_vld && !trail_vld) |-> !pause_front);

endmodule

// File: tb/test_ldu_stall_ctrl.sv
`timescale 1ns/1ps
module test_ldu_stall_ctrl;

   localparam logic [4:0] NOP = 5'd0, ADD = 5'd1, SUB = 5'd2, ADDI = 5'd3,
                          LDA = 5'd4, LD = 5'd5, ST = 5'd6, BR = 5'd7, BRL = 5'd8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [4:0] s2_op = '0, s2_fa = '0, s2_fb = '0, s2_fc = '0;
   logic [4:0] s3_op = '0, s3_dst = '0;
   logic s3_vld = 1'b0;
   logic pause2, bub2, pause1, bub1;

   always #2.5 clk = ~clk;

   ldu_stall_ctrl i_ldu_stall_ctrl (
      .clk(clk), .rst_n(rst_n), .s2_op(s2_op), .s2_fa(s2_fa), .s2_fb(s2_fb), .s2_fc(s2_fc),
      .s3_op(s3_op), .s3_dst(s3_dst), .s3_vld(s3_vld),
      .pause_front(pause2), .bubble_s3(bub2));

   // R10: second copy without the load record, narrower register file
   ldu_stall_ctrl #(.NREG(16), .OP_W(5), .LOAD_BR_GAP(1)) i_ldu_stall_ctrl_g1 (
      .clk(clk), .rst_n(rst_n), .s2_op(s2_op), .s2_fa(s2_fa[3:0]), .s2_fb(s2_fb[3:0]),
      .s2_fc(s2_fc[3:0]), .s3_op(s3_op), .s3_dst(s3_dst[3:0]), .s3_vld(s3_vld),
      .pause_front(pause1), .bubble_s3(bub1));

   typedef struct {
      logic  e2;
      logic  e1;
      string req;
   } exp_t;

   exp_t sb[$];
   int checks = 0;
   int failures = 0;
   bit done = 1'b0;
   logic prev_ld = 1'b0;
   logic [4:0] prev_dst = '0;

   function automatic logic model(input logic gap2);
      logic load3, early3, opm, brm, brm4;
      load3  = s3_vld && s3_op == LD;
      early3 = s3_vld && (s3_op == ADD || s3_op == SUB || s3_op == ADDI || s3_op == LDA);
      case (s2_op)
         ADD, SUB:       opm = (s2_fb == s3_dst) || (s2_fc == s3_dst);
         ADDI, LDA, LD:  opm = (s2_fb == s3_dst);
         ST:             opm = (s2_fb == s3_dst) || (s2_fa == s3_dst);
         default:        opm = 1'b0;
      endcase
      brm  = (s2_op == BR || s2_op == BRL) && ((s2_fb == s3_dst) || (s2_fc == s3_dst));
      brm4 = (s2_op == BR || s2_op == BRL) && prev_ld && ((s2_fb == prev_dst) || (s2_fc == prev_dst));
      return (load3 && (opm || brm)) || (early3 && brm) || (gap2 && brm4);
   endfunction

   task automatic step(input logic [4:0] op2, input logic [4:0] fa, input logic [4:0] fb,
                       input logic [4:0] fc, input logic [4:0] op3, input logic [4:0] dst3,
                       input logic v3, input string req);
      exp_t e;
      @(negedge clk);
      rst_n = 1'b1;
      s2_op = op2; s2_fa = fa; s2_fb = fb; s2_fc = fc;
      s3_op = op3; s3_dst = dst3; s3_vld = v3;
      e.e2 = model(1'b1);
      e.e1 = model(1'b0);
      e.req = req;
      sb.push_back(e);
      prev_ld  = v3 && (op3 == LD);
      prev_dst = dst3;
   endtask

   task automatic reset_cycle(input logic [4:0] op2, input logic [4:0] fb, input string req);
      exp_t e;
      @(negedge clk);
      rst_n = 1'b0;
      s2_op = op2; s2_fa = '0; s2_fb = fb; s2_fc = '0;
      s3_op = NOP; s3_dst = '0; s3_vld = 1'b0;
      prev_ld = 1'b0;
      e.e2 = model(1'b1);
      e.e1 = model(1'b0);
      e.req = req;
      sb.push_back(e);
   endtask

   // monitor: compares one queued expectation per cycle, away from the edge
   always @(negedge clk) begin
      exp_t e;
      #1;
      if (sb.size() != 0) begin
         e = sb.pop_front();
         checks += 2;
         if (pause2 !== e.e2 || bub2 !== e.e2) begin
            failures++;
            $display("FAIL %s gap2 pause=%b bubble=%b expected=%b (R7 pairing)", e.req, pause2, bub2, e.e2);
         end
         if (pause1 !== e.e1 || bub1 !== e.e1) begin
            failures++;
            $display("FAIL %s R10 gap1 pause=%b bubble=%b expected=%b", e.req, pause1, bub1, e.e1);
         end
      end
   end

   initial begin
      #100000;
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      reset_cycle(NOP, 5'd0, "R8 reset state");
      reset_cycle(NOP, 5'd0, "R8 reset state");
      step(ADD, 1, 4, 2, LD, 4, 1, "R1 add fb after load");
      step(SUB, 1, 2, 4, NOP, 0, 0, "R3 trailing load vs operand");
      step(ADD, 1, 2, 3, LD, 4, 1, "R1 no match");
      step(ST, 4, 5, 6, LD, 4, 1, "R1 store data");
      step(LD, 7, 4, 0, LD, 4, 1, "R1 load base");
      step(ADDI, 1, 2, 4, LD, 4, 1, "R6 addi fc unread");
      step(ST, 1, 2, 4, LD, 4, 1, "R6 store fc unread");
      step(ADD, 1, 4, 2, LD, 4, 0, "R5 invalid load");
      step(BR, 0, 4, 0, LD, 4, 1, "R2 branch target after load");
      step(BR, 0, 4, 0, NOP, 0, 0, "R3 second branch stall");
      step(BR, 0, 4, 0, NOP, 0, 0, "R3 released");
      step(BRL, 0, 9, 4, LD, 4, 1, "R2 branch condition after load");
      step(BR, 0, 4, 0, ADD, 4, 1, "R4 branch after add");
      step(BR, 0, 4, 0, NOP, 0, 0, "R4 released");
      step(ADD, 1, 4, 4, ADD, 4, 1, "R4 add forwarded");
      step(BR, 0, 3, 0, LDA, 3, 1, "R4 branch after load-address");
      step(BR, 0, 3, 0, BRL, 3, 1, "R5 link writer");
      step(ADD, 1, 3, 3, ST, 3, 1, "R5 store in stage 3");
      step(5'd15, 3, 3, 3, LD, 3, 1, "R9 unknown stage-2 opcode");
      step(BR, 3, 3, 3, 5'd15, 3, 1, "R9 unknown stage-3 opcode");
      step(NOP, 0, 0, 0, LD, 4, 1, "R8 load before reset");
      reset_cycle(BR, 5'd4, "R8 during reset");
      step(BR, 0, 4, 0, NOP, 0, 0, "R8 after reset");
      step(NOP, 0, 0, 0, NOP, 0, 0, "R7 idle");
      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule